// File: doc/BRIEF.md
# ADC Conversion Result and Status Bank

This block sits between an analog-to-digital converter core and the system register bus. Each time the converter finishes a sample it hands over a 12-bit value together with the number of the channel it sampled. The block stores that value in a register private to that channel and also in one shared "most recent result" register, which additionally records the channel number. Status flags record which channels hold unread results and whether any new result is waiting.

The flags are cleared by the act of reading. Reading a channel's register clears that channel's flag. Reading the shared register clears the global ready flag and the flag of the channel that produced the shared value. When the ready flag goes from low to high, the block emits a single-cycle request to an attached DMA engine. An interrupt line is raised whenever a set flag has its enable bit set. A write to the control register can also issue a one-cycle start pulse to the converter.

Reads have one cycle of latency: `bus_rdata` shows the value in the cycle after the read access. A clear caused by a read takes effect at that same clock edge.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, every channel register, the shared register, all flags and the enable register read as zero, and `irq`, `dma_req` and `start_pulse` are low.
- R2: A cycle with `conv_valid` high stores `conv_data` in the register of channel `conv_ch` (address 16 + channel) and in the shared register at address 3. The shared register holds the value in bits [11:0] and the channel number in bits [14:12].
- R3: A completed conversion sets the channel flag and the ready flag. The status register at address 1 shows channel flag i at bit i and the ready flag at bit 8.
- R4: `dma_req` is high for exactly one cycle, in the first cycle that the ready flag reads set after having been clear. A conversion that arrives while the ready flag is already set produces no request.
- R5: Reading a channel register returns its value and clears only that channel's flag.
- R6: Reading the shared register returns value and channel and clears both the ready flag and the flag of the channel recorded in it.
- R7: When a conversion and a clearing read hit the same flag in the same cycle, the flag ends up set. A read of a channel register in that cycle returns the previous value.
- R8: The enable register at address 2 is read/write, with the same bit layout as the status register. `irq` is high exactly when some flag is set and its enable bit is set.
- R9: Writing the control register at address 0 with bit 0 set makes `start_pulse` high for exactly the following cycle. A write with bit 0 clear gives no pulse, and the control register always reads zero.
- R10: Reading the status register clears nothing.
- R11: Writes to the status, shared and channel registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid | input | 1 | Converter finished a sample this cycle |
| conv_ch | input | 3 | Channel of the finished sample |
| conv_data | input | 12 | Sample value |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| start_pulse | output | 1 | One-cycle conversion start to the converter |
| dma_req | output | 1 | One-cycle transfer request to a DMA channel |
| irq | output | 1 | Interrupt, OR of enabled set flags |

## Verification
The capture path is tried with single conversions, back-to-back conversions on different channels, and extreme data and channel values (channel 0 and 7, values 0x000 and 0xFFF). Together these separate a correct per-channel write from a mis-steered one and a correct packing of the shared register from a truncated one. The clearing paths are tried with reads of a channel register and of the shared register, both alone and in the same cycle as a new conversion on the same or on a different channel. This tells apart set-wins priority, clearing of the recorded channel rather than the incoming one, and over-eager clearing. DMA requests are compared across conversions that arrive with the ready flag clear and with it already set, which tells edge-triggering apart from level-triggering.

// File: rtl/adcbank_pkg.sv
package adcbank_pkg;

    // Word offsets on the register port
    localparam int unsigned OFS_CTRL      = 0;
    localparam int unsigned OFS_STATUS    = 1;
    localparam int unsigned OFS_IEN       = 2;
    localparam int unsigned OFS_LAST      = 3;
    localparam int unsigned OFS_CHAN_BASE = 16;

    // Bit of the control word that launches a conversion
    localparam int unsigned START_BIT = 0;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTRL,
        REG_STATUS,
        REG_IEN,
        REG_LAST,
        REG_CHAN
    } reg_kind_e;

endpackage

// File: rtl/adcbank_decode.sv
module adcbank_decode
    import adcbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned CH_W   = 3
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_kind_e         kind,
    output logic [CH_W-1:0]   ch_idx,
    output logic              rd_stb,
    output logic              wr_stb
);

    logic [ADDR_W:0] rel;

    always_comb begin
        rel    = {1'b0, bus_addr} - (ADDR_W+1)'(OFS_CHAN_BASE);
        kind   = REG_NONE;
        ch_idx = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            kind = REG_CTRL;
        end else if (bus_addr == ADDR_W'(OFS_STATUS)) begin
            kind = REG_STATUS;
        end else if (bus_addr == ADDR_W'(OFS_IEN)) begin
            kind = REG_IEN;
        end else if (bus_addr == ADDR_W'(OFS_LAST)) begin
            kind = REG_LAST;
        end else if (bus_addr >= ADDR_W'(OFS_CHAN_BASE) &&
                     rel < (ADDR_W+1)'(NUM_CH)) begin
            kind   = REG_CHAN;
            ch_idx = rel[CH_W-1:0];
        end
        rd_stb = bus_sel && !bus_wr;
        wr_stb = bus_sel && bus_wr;
    end

endmodule

// File: rtl/adcbank_store.sv
module adcbank_store #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 12,
    parameter int unsigned CH_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cap_vld,
    input  logic [CH_W-1:0]                cap_ch,
    input  logic [DATA_W-1:0]              cap_data,
    output logic [NUM_CH-1:0][DATA_W-1:0]  chan_val,
    output logic [DATA_W-1:0]              last_val,
    output logic [CH_W-1:0]                last_ch
);

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] chan;
        logic [DATA_W-1:0]             lval;
        logic [CH_W-1:0]               lch;
    } store_t;

    store_t            st_d, st_q;
    logic [NUM_CH-1:0] we;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_we
        assign we[i] = cap_vld && (cap_ch == CH_W'(i));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (we[i]) st_d.chan[i] = cap_data;
        end
        if (cap_vld) begin
            st_d.lval = cap_data;
            st_d.lch  = cap_ch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chan_val = st_q.chan;
    assign last_val = st_q.lval;
    assign last_ch  = st_q.lch;

    p_last_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |=> (last_val == $past(cap_data)) && (last_ch == $past(cap_ch)));

    p_chan_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |=> chan_val[$past(cap_ch)] == $past(cap_data));

endmodule

// File: rtl/adcbank_flags.sv
module adcbank_flags #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld,
    input  logic [CH_W-1:0]   set_ch,
    input  logic              clr_ch_stb,
    input  logic [CH_W-1:0]   clr_ch_idx,
    input  logic              clr_last_stb,
    input  logic [CH_W-1:0]   last_ch,
    input  logic              ien_wr,
    input  logic [NUM_CH:0]   ien_wdata,
    output logic [NUM_CH-1:0] eoc,
    output logic              drdy,
    output logic [NUM_CH:0]   ien,
    output logic              dma_req,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] eoc;
        logic              drdy;
        logic [NUM_CH:0]   ien;
        logic              dma;
    } flag_t;

    flag_t             fl_d, fl_q;
    logic [NUM_CH-1:0] set_vec, clr_vec;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_vec
        assign set_vec[i] = set_vld && (set_ch == CH_W'(i));
        assign clr_vec[i] = (clr_ch_stb   && (clr_ch_idx == CH_W'(i))) ||
                            (clr_last_stb && (last_ch    == CH_W'(i)));
    end

    always_comb begin
        fl_d     = fl_q;
        // a set in the same cycle as a clear leaves the flag set
        fl_d.eoc = (fl_q.eoc & ~clr_vec) | set_vec;
        if (set_vld)           fl_d.drdy = 1'b1;
        else if (clr_last_stb) fl_d.drdy = 1'b0;
        fl_d.dma = fl_d.drdy && !fl_q.drdy;
        if (ien_wr) fl_d.ien = ien_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign eoc     = fl_q.eoc;
    assign drdy    = fl_q.drdy;
    assign ien     = fl_q.ien;
    assign dma_req = fl_q.dma;
    assign irq     = |({fl_q.drdy, fl_q.eoc} & fl_q.ien);

    p_dma_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> drdy && !$past(drdy));

    p_dma_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> drdy && eoc[$past(set_ch)]);

    p_drdy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_last_stb && !set_vld) |=> !drdy);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adcbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 12,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned BUS_W  = 32,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [CH_W-1:0]   conv_ch,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              start_pulse,
    output logic              dma_req,
    output logic              irq
);

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
        logic             start;
    } top_t;

    top_t                          tp_d, tp_q;
    reg_kind_e                     kind;
    logic [CH_W-1:0]               ch_idx;
    logic                          rd_stb, wr_stb;
    logic                          cap_vld;
    logic [NUM_CH-1:0][DATA_W-1:0] chan_val;
    logic [DATA_W-1:0]             last_val;
    logic [CH_W-1:0]               last_ch;
    logic [NUM_CH-1:0]             eoc;
    logic                          drdy;
    logic [NUM_CH:0]               ien;
    logic                          unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:NUM_CH+1];

    // Channel numbers past NUM_CH exist only when NUM_CH is not a power of two
    if (NUM_CH == (1 << CH_W)) begin : g_full_range
        assign cap_vld = conv_valid;
    end else begin : g_part_range
        assign cap_vld = conv_valid && (conv_ch < CH_W'(NUM_CH));
    end

    adcbank_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W)
    ) u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .kind     (kind),
        .ch_idx   (ch_idx),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb)
    );

    adcbank_store #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .CH_W   (CH_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_vld  (cap_vld),
        .cap_ch   (conv_ch),
        .cap_data (conv_data),
        .chan_val (chan_val),
        .last_val (last_val),
        .last_ch  (last_ch)
    );

    adcbank_flags #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_vld      (cap_vld),
        .set_ch       (conv_ch),
        .clr_ch_stb   (rd_stb && kind == REG_CHAN),
        .clr_ch_idx   (ch_idx),
        .clr_last_stb (rd_stb && kind == REG_LAST),
        .last_ch      (last_ch),
        .ien_wr       (wr_stb && kind == REG_IEN),
        .ien_wdata    (bus_wdata[NUM_CH:0]),
        .eoc          (eoc),
        .drdy         (drdy),
        .ien          (ien),
        .dma_req      (dma_req),
        .irq          (irq)
    );

    always_comb begin
        tp_d       = tp_q;
        tp_d.start = wr_stb && (kind == REG_CTRL) && bus_wdata[START_BIT];
        if (rd_stb) begin
            unique case (kind)
                REG_STATUS: tp_d.rdata = BUS_W'({drdy, eoc});
                REG_IEN:    tp_d.rdata = BUS_W'(ien);
                REG_LAST:   tp_d.rdata = BUS_W'({last_ch, last_val});
                REG_CHAN:   tp_d.rdata = BUS_W'(chan_val[ch_idx]);
                default:    tp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign bus_rdata   = tp_q.rdata;
    assign start_pulse = tp_q.start;

    p_start_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(bus_sel && bus_wr &&
                              bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[START_BIT]));

    p_ctrl_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) |=> bus_rdata == '0);

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    p_status_read_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_STATUS)) |=>
            (drdy >= $past(drdy)) && ((eoc & $past(eoc)) == $past(eoc)));

endmodule

// File: tb/tb_adc_result_bank.sv
module tb_adc_result_bank;

    localparam int CLK_PERIOD = 10;
    localparam int A_CTRL = 0, A_STAT = 1, A_IEN = 2, A_LAST = 3, A_CH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [2:0]  conv_ch = '0;
    logic [11:0] conv_data = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        start_pulse, dma_req, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_result_bank dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_valid  (conv_valid),
        .conv_ch     (conv_ch),
        .conv_data   (conv_data),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .start_pulse (start_pulse),
        .dma_req     (dma_req),
        .irq         (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    // drive at falling edge, one rising edge, release at next falling edge
    task automatic conv(input logic [2:0] ch, input logic [11:0] d, output logic dma_seen);
        conv_valid = 1'b1; conv_ch = ch; conv_data = d;
        @(posedge clk); @(negedge clk);
        conv_valid = 1'b0;
        dma_seen = dma_req;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(a);
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_with_conv(input int a, input logic [2:0] ch, input logic [11:0] d,
                                  output logic [31:0] rd);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(a);
        conv_valid = 1'b1; conv_ch = ch; conv_data = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; conv_valid = 1'b0;
        rd = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk_eq("R1 irq", 32'(irq), 0);
        chk_eq("R1 dma_req", 32'(dma_req), 0);
        chk_eq("R1 start_pulse", 32'(start_pulse), 0);
        bus_read(A_STAT, r);   chk_eq("R1 status", r, 0);
        bus_read(A_LAST, r);   chk_eq("R1 last", r, 0);
        bus_read(A_CH + 7, r); chk_eq("R1 ch7", r, 0);
        bus_read(A_IEN, r);    chk_eq("R1 ien", r, 0);
    endtask

    task automatic t_capture();
        logic [31:0] r; logic dm;
        conv(3'd3, 12'hABC, dm);
        chk_eq("R4 dma on first ready", 32'(dm), 1);
        bus_read(A_STAT, r);   chk_eq("R3 status after conv", r, 32'h108);
        bus_read(A_STAT, r);   chk_eq("R10 status read keeps flags", r, 32'h108);
        bus_read(A_CH + 3, r); chk_eq("R2 ch3 value", r, 32'hABC);
        bus_read(A_STAT, r);   chk_eq("R5 only eoc3 cleared", r, 32'h100);
        bus_read(A_LAST, r);   chk_eq("R6 last value", r, 32'h3ABC);
        bus_read(A_STAT, r);   chk_eq("R6 ready cleared", r, 0);
    endtask

    task automatic t_ready_held();
        logic [31:0] r; logic dm;
        conv(3'd1, 12'h111, dm); chk_eq("R4 dma first", 32'(dm), 1);
        conv(3'd5, 12'h555, dm); chk_eq("R4 no dma while ready set", 32'(dm), 0);
        bus_read(A_STAT, r);   chk_eq("R3 two channels", r, 32'h122);
        bus_read(A_CH + 1, r); chk_eq("R5 ch1 value", r, 32'h111);
        bus_read(A_STAT, r);   chk_eq("R5 eoc5 kept", r, 32'h120);
        bus_read(A_LAST, r);   chk_eq("R2 last is ch5", r, 32'h5555);
        bus_read(A_STAT, r);   chk_eq("R6 eoc5 and ready cleared", r, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] r; logic dm;
        conv(3'd2, 12'h222, dm);
        read_with_conv(A_CH + 2, 3'd2, 12'h2A2, r);
        chk_eq("R7 read returns old value", r, 32'h222);
        bus_read(A_STAT, r);   chk_eq("R7 eoc2 kept set", r, 32'h104);
        bus_read(A_CH + 2, r); chk_eq("R7 new value stored", r, 32'h2A2);
        bus_read(A_STAT, r);   chk_eq("R5 eoc2 cleared", r, 32'h100);
        conv(3'd2, 12'h2B2, dm);
        read_with_conv(A_LAST, 3'd6, 12'h666, r);
        chk_eq("R6 last before new conv", r, 32'h22B2);
        bus_read(A_STAT, r);   chk_eq("R7 old ch cleared new set", r, 32'h140);
        bus_read(A_LAST, r);   chk_eq("R2 last now ch6", r, 32'h6666);
        bus_read(A_STAT, r);   chk_eq("R6 all clear", r, 0);
    endtask

    task automatic t_irq();
        logic [31:0] r; logic dm;
        bus_write(A_IEN, 32'h010);
        bus_read(A_IEN, r);    chk_eq("R8 ien readback", r, 32'h010);
        conv(3'd0, 12'h000, dm);
        chk_eq("R8 irq masked", 32'(irq), 0);
        conv(3'd4, 12'hFFF, dm);
        chk_eq("R8 irq on enabled eoc4", 32'(irq), 1);
        bus_read(A_CH + 4, r); chk_eq("R2 ch4 full scale", r, 32'hFFF);
        chk_eq("R8 irq drops", 32'(irq), 0);
        bus_write(A_IEN, 32'h110);
        chk_eq("R8 irq on ready", 32'(irq), 1);
        bus_read(A_LAST, r);   chk_eq("R6 last ch4", r, 32'h4FFF);
        chk_eq("R8 irq after ready clear", 32'(irq), 0);
        bus_read(A_STAT, r);   chk_eq("R5 eoc0 still set", r, 32'h001);
        bus_read(A_CH + 0, r); chk_eq("R2 ch0 zero value", r, 0);
        bus_write(A_IEN, 32'h0);
    endtask

    task automatic t_start();
        logic [31:0] r;
        bus_write(A_CTRL, 32'h1);
        chk_eq("R9 start pulse", 32'(start_pulse), 1);
        @(negedge clk);
        chk_eq("R9 start one cycle", 32'(start_pulse), 0);
        bus_read(A_CTRL, r);   chk_eq("R9 ctrl reads zero", r, 0);
        bus_write(A_CTRL, 32'h2);
        chk_eq("R9 no start without bit0", 32'(start_pulse), 0);
    endtask

    task automatic t_read_only();
        logic [31:0] r; logic dm;
        conv(3'd7, 12'h7F7, dm);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_write(A_LAST, 32'h0);
        bus_write(A_CH + 7, 32'h0);
        bus_read(A_STAT, r);   chk_eq("R11 status unchanged", r, 32'h180);
        bus_read(A_CH + 7, r); chk_eq("R11 ch7 unchanged", r, 32'h7F7);
        bus_read(A_LAST, r);   chk_eq("R11 last unchanged", r, 32'h77F7);
        bus_read(A_STAT, r);   chk_eq("R6 clear after ch7", r, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture();
        t_ready_held();
        t_set_wins();
        t_irq();
        t_start();
        t_read_only();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule